// File: doc/BRIEF.md
# Page Write Buffer Controller

This block sits behind a two-wire serial memory protocol engine and gathers the data bytes of one write transaction into a page buffer. Nothing reaches the memory array while bytes are arriving. When the engine reports a STOP, the buffered bytes are committed to a simple byte-write memory port. The block then holds a busy flag for a self-timed write period, and the engine uses that flag to withhold acknowledges.

The protocol engine delivers four kinds of event as single-cycle pulses: START (first or repeated), a full word address (page bits plus in-page offset), a received data byte, and STOP. The block keeps the address pointer. Each data byte advances only the in-page offset, so a long write wraps within its page and newer bytes replace older ones in the same slots. A per-slot valid mask makes sure that only slots written since the last START are committed. A write-protect input cancels the commit and its busy period. The length of the write period is a parameter in system clocks.

Top module: `pwb_ctrl`

## Requirements
- R1: After reset, busy_o is 0, mem_we_o is 0 and ptr_o is 0.
- R2: While busy_o is 0, an addr_valid_i pulse loads ptr_o with addr_i, visible in the next cycle.
- R3: Each accepted data byte stores to slot ptr_o[3:0] and then increments ptr_o[3:0] modulo 16. ptr_o[10:4] is unchanged, so a write that runs past the last slot continues at slot 0 of the same page.
- R4: mem_we_o stays 0 while bytes are being collected. The array is written only after STOP.
- R5: On STOP with at least one buffered byte and wp_i low, busy_o rises in the next cycle. The 16 slots are then scanned one per cycle in ascending slot order, and each valid slot is written at address {ptr_o[10:4], slot}.
- R6: When more than 16 bytes arrive before STOP, each slot holds the latest byte written to it. The page is committed with at most 16 writes.
- R7: Only slots written since the most recent START are committed. Other locations of the page keep their contents.
- R8: A transaction with a single data byte produces exactly one array write.
- R9: If wp_i is 1 at STOP, no array write occurs, busy_o stays 0 and the buffered bytes are discarded.
- R10: A STOP or a repeated START with no buffered data byte produces no write and no busy period. The pointer keeps the loaded address.
- R11: busy_o stays high for exactly 16 + CYCLE_CLKS consecutive cycles after a commit is launched.
- R12: While busy_o is 1, START, address and data inputs are ignored. ptr_o does not change and no extra write results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | START or repeated START event pulse |
| stop_i | input | 1 | STOP event pulse |
| addr_valid_i | input | 1 | Word address received pulse |
| addr_i | input | ADDR_W | Full word address (page and offset) |
| data_valid_i | input | 1 | Data byte received pulse |
| data_i | input | DATA_W | Received data byte |
| wp_i | input | 1 | Write protect, 1 blocks commits |
| busy_o | output | 1 | Commit or write period in progress |
| ptr_o | output | ADDR_W | Current address pointer |
| mem_we_o | output | 1 | Array byte write strobe |
| mem_addr_o | output | ADDR_W | Array write address |
| mem_wdata_o | output | DATA_W | Array write data |

## Verification
The bench builds the block with an 11-bit address, 16-byte pages and CYCLE_CLKS set to 20 instead of a multi-millisecond count. The short setting lets the exact 36-cycle busy window be counted and many commits run back to back. With the real page size kept, the offset wrap at the page end, the 17th and 18th byte overwrites and the ascending slot scan all appear at their true boundaries.

// File: rtl/pwb_pkg.sv
package pwb_pkg;
  typedef enum logic [1:0] {
    ST_COLLECT = 2'd0,
    ST_COMMIT  = 2'd1,
    ST_WAIT    = 2'd2
  } pwb_state_e;
endpackage

// File: rtl/pwb_addr_ptr.sv
module pwb_addr_ptr #(
  parameter int ADDR_W = 11,
  parameter int OFS_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              inc_i,
  output logic [ADDR_W-1:0] ptr_o
);
  logic [ADDR_W-1:0] ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q <= '0;
    end else if (load_i) begin
      ptr_q <= addr_i;
    end else if (inc_i) begin
      // only the in-page offset moves
      ptr_q[OFS_W-1:0] <= ptr_q[OFS_W-1:0] + 1'b1;
    end
  end

  assign ptr_o = ptr_q;
endmodule

// File: rtl/pwb_page_buf.sv
module pwb_page_buf #(
  parameter int PAGE_BYTES = 16,
  parameter int DATA_W     = 8,
  localparam int OFS_W     = $clog2(PAGE_BYTES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              we_i,
  input  logic [OFS_W-1:0]  widx_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [OFS_W-1:0]  ridx_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rvalid_o,
  output logic              any_o
);
  logic [DATA_W-1:0]     slot_q [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] vld_q;

  for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        slot_q[g] <= '0;
        vld_q[g]  <= 1'b0;
      end else if (clr_i) begin
        vld_q[g]  <= 1'b0;
      end else if (we_i && widx_i == OFS_W'(g)) begin
        slot_q[g] <= wdata_i;
        vld_q[g]  <= 1'b1;
      end
    end
  end

  assign rdata_o  = slot_q[ridx_i];
  assign rvalid_o = vld_q[ridx_i];
  assign any_o    = |vld_q;
endmodule

// File: rtl/pwb_cycle_timer.sv
module pwb_cycle_timer #(
  parameter int CYCLE_CLKS = 1000000,
  localparam int CNT_W     = (CYCLE_CLKS > 1) ? $clog2(CYCLE_CLKS) : 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic done_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else if (start_i) begin
      cnt_q <= CNT_W'(CYCLE_CLKS - 1);
      run_q <= 1'b1;
    end else if (run_q) begin
      if (cnt_q == '0) run_q <= 1'b0;
      else             cnt_q <= cnt_q - 1'b1;
    end
  end

  assign done_o = run_q && (cnt_q == '0);
endmodule

// File: rtl/pwb_ctrl.sv
module pwb_ctrl
  import pwb_pkg::*;
#(
  parameter int ADDR_W     = 11,
  parameter int DATA_W     = 8,
  parameter int PAGE_BYTES = 16,
  parameter int CYCLE_CLKS = 1000000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              addr_valid_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              data_valid_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              wp_i,
  output logic              busy_o,
  output logic [ADDR_W-1:0] ptr_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o
);
  localparam int OFS_W  = $clog2(PAGE_BYTES);
  localparam int PAGE_W = ADDR_W - OFS_W;

  pwb_state_e       state_q, state_d;
  logic [OFS_W-1:0] idx_q;
  logic             idle, launch, last_slot, commit_end;
  logic             buf_clr, buf_we, buf_any, slot_vld, tmr_done;
  logic [DATA_W-1:0] slot_data;

  assign idle       = (state_q == ST_COLLECT);
  assign launch     = idle && stop_i && buf_any && !wp_i;
  assign last_slot  = (idx_q == OFS_W'(PAGE_BYTES - 1));
  assign commit_end = (state_q == ST_COMMIT) && last_slot;
  assign buf_we     = idle && data_valid_i && !stop_i && !addr_valid_i;
  // mask drops on START, on a STOP that launches nothing, and after a commit
  assign buf_clr    = (idle && stop_i && !launch) ||
                      (idle && start_i && !stop_i) || commit_end;

  pwb_addr_ptr #(.ADDR_W(ADDR_W), .OFS_W(OFS_W)) u_ptr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (idle && addr_valid_i && !stop_i),
    .addr_i (addr_i),
    .inc_i  (buf_we),
    .ptr_o  (ptr_o)
  );

  pwb_page_buf #(.PAGE_BYTES(PAGE_BYTES), .DATA_W(DATA_W)) u_buf (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (buf_clr),
    .we_i     (buf_we),
    .widx_i   (ptr_o[OFS_W-1:0]),
    .wdata_i  (data_i),
    .ridx_i   (idx_q),
    .rdata_o  (slot_data),
    .rvalid_o (slot_vld),
    .any_o    (buf_any)
  );

  pwb_cycle_timer #(.CYCLE_CLKS(CYCLE_CLKS)) u_tmr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (commit_end),
    .done_o  (tmr_done)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_COLLECT: if (launch)     state_d = ST_COMMIT;
      ST_COMMIT:  if (last_slot)  state_d = ST_WAIT;
      ST_WAIT:    if (tmr_done)   state_d = ST_COLLECT;
      default:                    state_d = ST_COLLECT;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_COLLECT;
      idx_q   <= '0;
    end else begin
      state_q <= state_d;
      if (launch)                     idx_q <= '0;
      else if (state_q == ST_COMMIT)  idx_q <= idx_q + 1'b1;
    end
  end

  assign busy_o      = !idle;
  assign mem_we_o    = (state_q == ST_COMMIT) && slot_vld;
  assign mem_addr_o  = {ptr_o[ADDR_W-1 -: PAGE_W], idx_q};
  assign mem_wdata_o = slot_data;
endmodule

// File: rtl/pwb_ctrl_chk.sv
module pwb_ctrl_chk #(
  parameter int ADDR_W     = 11,
  parameter int PAGE_BYTES = 16,
  parameter int CYCLE_CLKS = 1000000
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              stop_i,
  input logic              addr_valid_i,
  input logic              data_valid_i,
  input logic              wp_i,
  input logic              busy_o,
  input logic [ADDR_W-1:0] ptr_o,
  input logic              mem_we_o
);
  localparam int OFS_W = $clog2(PAGE_BYTES);
  localparam logic [31:0] BUSY_LEN = 32'(PAGE_BYTES + CYCLE_CLKS);

  logic [31:0] run_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) run_q <= '0;
    else         run_q <= busy_o ? run_q + 32'd1 : 32'd0;
  end

  AST_WE_AFTER_STOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> busy_o);  // R4
  AST_BUSY_FROM_STOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(stop_i));  // R5
  AST_WP_NO_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_i && wp_i && !busy_o) |=> !busy_o);  // R9
  AST_PAGE_FIXED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_valid_i && !addr_valid_i && !stop_i && !busy_o) |=>
      ($stable(ptr_o[ADDR_W-1:OFS_W]) &&
       ptr_o[OFS_W-1:0] == $past(ptr_o[OFS_W-1:0]) + 1'b1));  // R3
  AST_PTR_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> $stable(ptr_o));  // R12
  AST_BUSY_LEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> run_q == BUSY_LEN);  // R11
endmodule

bind pwb_ctrl pwb_ctrl_chk #(
  .ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES), .CYCLE_CLKS(CYCLE_CLKS)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .stop_i       (stop_i),
  .addr_valid_i (addr_valid_i),
  .data_valid_i (data_valid_i),
  .wp_i         (wp_i),
  .busy_o       (busy_o),
  .ptr_o        (ptr_o),
  .mem_we_o     (mem_we_o)
);

// File: tb/pwb_ctrl_tb.sv
module pwb_ctrl_tb;
  localparam int AW = 11;
  localparam int DW = 8;
  localparam int PB = 16;
  localparam int CC = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 0, stop = 0, av = 0, dv = 0, wp = 0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] data = '0;
  logic busy, mem_we;
  logic [AW-1:0] ptr, mem_addr;
  logic [DW-1:0] mem_wdata;

  always #5 clk = ~clk;

  pwb_ctrl #(.ADDR_W(AW), .DATA_W(DW), .PAGE_BYTES(PB), .CYCLE_CLKS(CC)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .stop_i(stop),
    .addr_valid_i(av), .addr_i(addr), .data_valid_i(dv), .data_i(data),
    .wp_i(wp), .busy_o(busy), .ptr_o(ptr), .mem_we_o(mem_we),
    .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata)
  );

  // array model
  logic [DW-1:0] shadow [1<<AW];
  logic [AW-1:0] wlog [64];
  int unsigned   n_wr;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < (1<<AW); i++) shadow[i] <= 8'hEE;
      n_wr <= 0;
    end else if (mem_we) begin
      shadow[mem_addr] <= mem_wdata;
      wlog[n_wr[5:0]]  <= mem_addr;
      n_wr <= n_wr + 1;
    end
  end

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
    end
  endtask

  task automatic ev_start();
    @(negedge clk) start = 1; @(negedge clk) start = 0;
  endtask
  task automatic ev_stop();
    @(negedge clk) stop = 1; @(negedge clk) stop = 0;
  endtask
  task automatic ev_addr(logic [AW-1:0] a);
    @(negedge clk) begin av = 1; addr = a; end @(negedge clk) av = 0;
  endtask
  task automatic ev_data(logic [DW-1:0] d);
    @(negedge clk) begin dv = 1; data = d; end @(negedge clk) dv = 0;
  endtask
  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  task automatic t_reset();
    check("R1 busy", busy, 0);
    check("R1 we", mem_we, 0);
    check("R1 ptr", ptr, 0);
  endtask

  task automatic t_byte_write();
    int base, n;
    base = n_wr;
    ev_start(); ev_addr(11'h123);
    check("R2 ptr load", ptr, 11'h123);
    ev_data(8'hA5);
    check("R3 ptr inc", ptr, 11'h124);
    check("R4 no early write", n_wr - base, 0);
    ev_stop();
    n = 0;
    while (busy) begin n++; @(negedge clk); end
    check("R11 busy length", n, PB + CC);
    check("R8 one write", n_wr - base, 1);
    check("R5 data", shadow[11'h123], 8'hA5);
  endtask

  task automatic t_page_wrap();
    int base;
    base = n_wr;
    ev_start(); ev_addr(11'h2FC);
    for (int i = 0; i < 6; i++) ev_data(8'h10 + 8'(i));
    check("R3 wrap ptr", ptr, 11'h2F2);
    check("R4 nothing before stop", n_wr - base, 0);
    ev_stop(); wait_idle();
    check("R5 count", n_wr - base, 6);
    check("R5 first slot", wlog[6'(base)], 11'h2F0);
    check("R5 last slot", wlog[6'(base + 5)], 11'h2FF);
    check("R3 at 2FC", shadow[11'h2FC], 8'h10);
    check("R3 wrapped 2F0", shadow[11'h2F0], 8'h14);
    check("R3 wrapped 2F1", shadow[11'h2F1], 8'h15);
    check("R3 no spill", shadow[11'h300], 8'hEE);
  endtask

  task automatic t_overflow();
    int base;
    base = n_wr;
    ev_start(); ev_addr(11'h400);
    for (int i = 0; i < 18; i++) ev_data(8'h80 + 8'(i));
    check("R6 ptr", ptr, 11'h402);
    ev_stop(); wait_idle();
    check("R6 count", n_wr - base, 16);
    check("R6 slot0", shadow[11'h400], 8'h90);
    check("R6 slot1", shadow[11'h401], 8'h91);
    check("R6 slot2", shadow[11'h402], 8'h82);
  endtask

  task automatic t_partial_mask();
    int base;
    ev_start(); ev_addr(11'h500);
    for (int i = 0; i < 16; i++) ev_data(8'(i));
    ev_stop(); wait_idle();
    base = n_wr;
    ev_start(); ev_addr(11'h505);
    ev_data(8'hC0); ev_data(8'hC1);
    ev_stop(); wait_idle();
    check("R7 count", n_wr - base, 2);
    check("R7 written", shadow[11'h506], 8'hC1);
    check("R7 kept below", shadow[11'h504], 8'h04);
    check("R7 kept above", shadow[11'h507], 8'h07);
  endtask

  task automatic t_wp();
    int base;
    base = n_wr;
    ev_start(); ev_addr(11'h600); ev_data(8'h55);
    wp = 1;
    ev_stop();
    check("R9 no busy", busy, 0);
    repeat (PB + 2) @(negedge clk);
    wp = 0;
    check("R9 no write", n_wr - base, 0);
    check("R9 array", shadow[11'h600], 8'hEE);
    // discarded: a later empty stop commits nothing
    ev_stop();
    check("R9 discarded", busy, 0);
  endtask

  task automatic t_no_data();
    int base;
    base = n_wr;
    ev_start(); ev_addr(11'h1AB); ev_start();
    check("R10 rstart busy", busy, 0);
    check("R10 ptr kept", ptr, 11'h1AB);
    ev_stop();
    check("R10 stop busy", busy, 0);
    repeat (3) @(negedge clk);
    check("R10 no write", n_wr - base, 0);
  endtask

  task automatic t_busy_ignore();
    int base;
    base = n_wr;
    ev_start(); ev_addr(11'h700); ev_data(8'h11); ev_stop();
    ev_start(); ev_addr(11'h050); ev_data(8'h99);
    check("R12 ptr frozen", ptr, 11'h701);
    wait_idle();
    repeat (2) @(negedge clk);
    check("R12 ptr after", ptr, 11'h701);
    check("R12 one write", n_wr - base, 1);
    check("R12 untouched", shadow[11'h050], 8'hEE);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_byte_write();
    t_page_wrap();
    t_overflow();
    t_partial_mask();
    t_wp();
    t_no_data();
    t_busy_ignore();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule